// File: doc/BRIEF.md
# MSI Doorbell to SPI Pulse Frame

This block is a message-signalled-interrupt frame that sits in a 4 KB little-endian register window. A bus master raises an interrupt by writing an interrupt number to the doorbell register. The frame keeps only the low ten bits of that number and checks it against a window of shared peripheral interrupt lines. The window starts at interrupt ID `BASE_SPI + 32` and holds `NUM_SPI` lines. A number inside the window gives a one-cycle pulse on the matching output line. A number outside the window is dropped without any sign.

Software finds the window through a read-only type register. An identification register gives a fixed product code. The upper identification area reads as zero. The register bus uses a valid/ready handshake. Reads return data one cycle after acceptance. Any access to an offset with no meaning for its direction gives a one-cycle error-flag pulse. Elaboration stops if the parameters put the window outside the allowed interrupt ID range.

Top module: `msi_spi_frame`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `spi_pulse`, `rsp_valid`, `rsp_rdata` and `bad_access` are zero. `req_ready` is low in reset and high from the first cycle after reset.
- R2: A 4-byte read of offset 0x008 returns `(BASE_SPI + 32) << 16 | NUM_SPI`.
- R3: A 4-byte read of offset 0xFCC returns 0x0510_0000.
- R4: A 4-byte read of any offset from 0xFD0 to 0xFFC inclusive returns zero and raises no error flag.
- R5: A doorbell write (offset 0x040) whose data bits [9:0] equal an ID `k` in `[BASE_SPI+32, BASE_SPI+32+NUM_SPI-1]` sets only `spi_pulse[k-BASE_SPI-32]`. The bit is high for exactly the one cycle after the write is accepted.
- R6: A doorbell write whose bits [9:0] fall outside the window gives no pulse and no error flag. Data bits [31:10] have no effect.
- R7: `req_size` codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. A read with any code other than 2 returns zero and raises no error flag, whatever the offset.
- R8: A write with size code 1 or 2 is carried out. A write with code 0 or 3 has no effect: no pulse and no error flag.
- R9: A size-legal read of an offset other than 0x008, 0xFCC or 0xFD0..0xFFC returns zero and pulses `bad_access` for one cycle. A size-legal write to any offset other than 0x040 gives no pulse and pulses `bad_access` for one cycle.
- R10: Doorbell writes accepted in consecutive cycles each give their own pulse, in consecutive cycles and in order.
- R11: Every accepted read gives `rsp_valid` high for exactly the next cycle. An accepted write never raises `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Frame can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the 4 KB window |
| req_wdata | input | 32 | Write data |
| req_size | input | 2 | Access size code (0:1 B, 1:2 B, 2:4 B, 3:8 B) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| bad_access | output | 1 | One-cycle pulse for an access to an undefined offset |
| spi_pulse | output | NUM_SPI | One-cycle interrupt pulses, bit i for ID BASE_SPI+32+i |

## Verification
Every result appears exactly one clock edge after the edge that accepts the request. This holds for read data with its valid strobe, for the error flag and for the interrupt pulse. The bench drives each request on a falling edge and holds it through one rising edge. It samples all outputs at the next falling edge, halfway into the cycle where the results are due. Back-to-back doorbells are checked at successive falling edges, one pulse per cycle. For reads and for writes that must not pulse, the bench also checks one cycle later that `rsp_valid` and the pulses have dropped again.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  localparam int          ADDR_W       = 12;
  localparam int          DATA_W       = 32;
  localparam int          IRQ_ID_W     = 10;
  localparam int          SPI_ID_OFS   = 32;
  localparam int          SPI_MAX      = 128;
  localparam int          IRQ_ID_LIMIT = 1020;

  localparam logic [11:0] OFS_TYPE     = 12'h008;
  localparam logic [11:0] OFS_DOORBELL = 12'h040;
  localparam logic [11:0] OFS_IDENT    = 12'hFCC;
  localparam logic [11:0] OFS_ZERO_LO  = 12'hFD0;
  localparam logic [11:0] OFS_ZERO_HI  = 12'hFFC;

  localparam logic [31:0] IDENT_VALUE  = 32'h51 << 20;

  function automatic logic read_size_ok(logic [1:0] sz);
    return sz == SZ_WORD;
  endfunction

  function automatic logic write_size_ok(logic [1:0] sz);
    return (sz == SZ_HALF) || (sz == SZ_WORD);
  endfunction

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
  import msi_frame_pkg::*;
#(
  parameter int FIRST_ID = 32,
  parameter int NUM_SPI  = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_known,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_doorbell
);

  localparam logic [DATA_W-1:0] TYPE_VALUE =
    (DATA_W'(FIRST_ID) << 16) | DATA_W'(NUM_SPI);

  always_comb begin
    rd_known = 1'b1;
    rd_data  = '0;
    if (addr == OFS_TYPE) begin
      rd_data = TYPE_VALUE;
    end else if (addr == OFS_IDENT) begin
      rd_data = IDENT_VALUE;
    end else if (addr >= OFS_ZERO_LO && addr <= OFS_ZERO_HI) begin
      rd_data = '0;
    end else begin
      rd_known = 1'b0;
    end
  end

  assign wr_doorbell = (addr == OFS_DOORBELL);

endmodule

// File: rtl/msi_doorbell.sv
module msi_doorbell
  import msi_frame_pkg::*;
#(
  parameter int FIRST_ID = 32,
  parameter int NUM_SPI  = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strobe,
  input  logic [IRQ_ID_W-1:0] irq_id,
  output logic [NUM_SPI-1:0]  pulse
);

  logic [NUM_SPI-1:0] hit;
  logic [NUM_SPI-1:0] pulse_q;

  // One comparator per line; an ID outside the window matches none of them.
  for (genvar i = 0; i < NUM_SPI; i++) begin : g_line
    assign hit[i] = (int'(irq_id) == FIRST_ID + i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= '0;
    end else begin
      pulse_q <= strobe ? hit : '0;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/msi_spi_frame.sv
module msi_spi_frame
  import msi_frame_pkg::*;
#(
  parameter int BASE_SPI = 0,
  parameter int NUM_SPI  = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [11:0]        req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [1:0]         req_size,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic               bad_access,
  output logic [NUM_SPI-1:0] spi_pulse
);

  localparam int FIRST_ID = BASE_SPI + SPI_ID_OFS;

  if (NUM_SPI < 1 || NUM_SPI > SPI_MAX || FIRST_ID + NUM_SPI > IRQ_ID_LIMIT)
  begin : g_cfg_bad
    $error("msi_spi_frame: interrupt window parameters out of range");
  end

  logic              ready_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              bad_q;
  logic              fire;
  logic              rd_ok;
  logic              wr_ok;
  logic              rd_known;
  logic [DATA_W-1:0] rd_data;
  logic              wr_doorbell;
  logic              ring;
  logic              unused_wdata_hi;

  assign fire  = req_valid && ready_q;
  assign rd_ok = fire && !req_write && read_size_ok(req_size);
  assign wr_ok = fire &&  req_write && write_size_ok(req_size);
  assign ring  = wr_ok && wr_doorbell;
  assign unused_wdata_hi = ^req_wdata[DATA_W-1:IRQ_ID_W];

  msi_reg_decode #(
    .FIRST_ID (FIRST_ID),
    .NUM_SPI  (NUM_SPI)
  ) decode_i (
    .addr        (req_addr),
    .rd_known    (rd_known),
    .rd_data     (rd_data),
    .wr_doorbell (wr_doorbell)
  );

  msi_doorbell #(
    .FIRST_ID (FIRST_ID),
    .NUM_SPI  (NUM_SPI)
  ) doorbell_i (
    .clk    (clk),
    .rst    (rst),
    .strobe (ring),
    .irq_id (req_wdata[IRQ_ID_W-1:0]),
    .pulse  (spi_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      bad_q       <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_q <= fire && !req_write;
      rsp_rdata_q <= (rd_ok && rd_known) ? rd_data : '0;
      bad_q       <= (rd_ok && !rd_known) || (wr_ok && !wr_doorbell);
    end
  end

  assign req_ready  = ready_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign bad_access = bad_q;

endmodule

// File: rtl/msi_spi_frame_chk.sv
module msi_spi_frame_chk #(
  parameter int NUM_SPI = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [11:0]        req_addr,
  input logic [1:0]         req_size,
  input logic               rsp_valid,
  input logic               bad_access,
  input logic [NUM_SPI-1:0] spi_pulse
);

  logic acc;
  assign acc = req_valid && req_ready;

  assert_pulse_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(spi_pulse));

  assert_pulse_from_doorbell_R5: assert property (@(posedge clk) disable iff (rst)
    (spi_pulse != '0) |-> $past(acc && req_write && req_addr == 12'h040));

  assert_no_pulse_bad_size_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && req_write && (req_size == 2'd0 || req_size == 2'd3)) |=>
      (spi_pulse == '0 && !bad_access));

  assert_doorbell_no_error_R9: assert property (@(posedge clk) disable iff (rst)
    (acc && req_write && req_addr == 12'h040) |=> !bad_access);

  assert_read_response_R11: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_write) |=> rsp_valid);

  assert_response_needs_read_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(acc && !req_write));

endmodule

bind msi_spi_frame msi_spi_frame_chk #(.NUM_SPI(NUM_SPI)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .rsp_valid  (rsp_valid),
  .bad_access (bad_access),
  .spi_pulse  (spi_pulse)
);

// File: tb/msi_spi_frame_tb.sv
module msi_spi_frame_tb_top;

  localparam int BASE = 3;
  localparam int NSPI = 8;
  localparam int FID  = BASE + 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic            req_write = 1'b0;
  logic [11:0]     req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic [1:0]      req_size = 2'd2;
  logic            rsp_valid;
  logic [31:0]     rsp_rdata;
  logic            bad_access;
  logic [NSPI-1:0] spi_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  msi_spi_frame #(.BASE_SPI(BASE), .NUM_SPI(NSPI)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_size   (req_size),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .bad_access (bad_access),
    .spi_pulse  (spi_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [NSPI-1:0] exp_pulse(input logic [31:0] d);
    int id;
    id = int'(d[9:0]);
    if (id >= FID && id < FID + NSPI) return NSPI'(1) << (id - FID);
    return '0;
  endfunction

  // Drive on a falling edge, accepted at the next rising edge; results sampled
  // at the falling edge after it.
  task automatic access(input logic wr, input logic [11:0] a,
                        input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_size  = sz;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    chk({req, " quiet rsp_valid"}, 32'(rsp_valid), 32'd0);
    chk({req, " quiet pulse"}, 32'(spi_pulse), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pulse in reset", 32'(spi_pulse), 32'd0);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk("R1 bad_access in reset", 32'(bad_access), 32'd0);
    chk("R1 rdata in reset", rsp_rdata, 32'd0);
    chk("R1 ready in reset", 32'(req_ready), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 pulse after reset", 32'(spi_pulse), 32'd0);

    // R2 type register
    access(1'b0, 12'h008, '0, 2'd2);
    chk("R2 type value", rsp_rdata, (32'(FID) << 16) | 32'(NSPI));
    chk("R2 rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R2 no error", 32'(bad_access), 32'd0);
    idle_check("R11 after read");

    // R3 identification register
    access(1'b0, 12'hFCC, '0, 2'd2);
    chk("R3 ident value", rsp_rdata, 32'h0510_0000);
    chk("R3 no error", 32'(bad_access), 32'd0);

    // R4 zero area, every offset
    for (int a = 12'hFD0; a <= 12'hFFC; a++) begin
      access(1'b0, 12'(a), '0, 2'd2);
      chk("R4 zero area data", rsp_rdata, 32'd0);
      chk("R4 zero area no error", 32'(bad_access), 32'd0);
    end

    // R5/R6 exhaustive doorbell sweep over all 10-bit IDs
    for (int id = 0; id < 1024; id++) begin
      access(1'b1, 12'h040, 32'(id), 2'd2);
      chk("R5 R6 doorbell pulse", 32'(spi_pulse), 32'(exp_pulse(32'(id))));
      chk("R6 doorbell no error", 32'(bad_access), 32'd0);
      chk("R11 write no rsp", 32'(rsp_valid), 32'd0);
    end
    idle_check("R5 single cycle");

    // R6 upper data bits ignored
    access(1'b1, 12'h040, 32'hFFFF_FC00 | 32'(FID + 2), 2'd2);
    chk("R6 upper bits set in window", 32'(spi_pulse), 32'(NSPI'(1) << 2));
    access(1'b1, 12'h040, 32'h0000_0400 | 32'(FID - 1), 2'd2);
    chk("R6 upper bits below window", 32'(spi_pulse), 32'd0);

    // R7 read sizes
    for (int s = 0; s < 4; s++) begin
      if (s != 2) begin
        access(1'b0, 12'h008, '0, 2'(s));
        chk("R7 bad read size data", rsp_rdata, 32'd0);
        chk("R7 bad read size no error", 32'(bad_access), 32'd0);
        chk("R7 bad read size rsp", 32'(rsp_valid), 32'd1);
        access(1'b0, 12'h100, '0, 2'(s));
        chk("R7 bad size unknown offset no error", 32'(bad_access), 32'd0);
      end
    end

    // R8 write sizes
    for (int s = 0; s < 4; s++) begin
      access(1'b1, 12'h040, 32'(FID + 5), 2'(s));
      chk("R8 write size pulse", 32'(spi_pulse),
          (s == 1 || s == 2) ? 32'(NSPI'(1) << 5) : 32'd0);
      chk("R8 write size no error", 32'(bad_access), 32'd0);
      access(1'b1, 12'h044, 32'(FID), 2'(s));
      chk("R8 R9 bad-offset write error by size", 32'(bad_access),
          (s == 1 || s == 2) ? 32'd1 : 32'd0);
    end

    // R9 undefined offsets
    begin
      logic [11:0] rd_bad [6] = '{12'h000, 12'h004, 12'h009, 12'h040, 12'hFC8, 12'hFFD};
      logic [11:0] wr_bad [4] = '{12'h008, 12'hFCC, 12'h044, 12'hFD0};
      foreach (rd_bad[i]) begin
        access(1'b0, rd_bad[i], '0, 2'd2);
        chk("R9 unknown read data", rsp_rdata, 32'd0);
        chk("R9 unknown read error", 32'(bad_access), 32'd1);
      end
      @(negedge clk);
      chk("R9 error single cycle", 32'(bad_access), 32'd0);
      foreach (wr_bad[i]) begin
        access(1'b1, wr_bad[i], 32'(FID + 1), 2'd2);
        chk("R9 unknown write no pulse", 32'(spi_pulse), 32'd0);
        chk("R9 unknown write error", 32'(bad_access), 32'd1);
      end
    end

    // R10 back-to-back doorbells
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h040; req_size = 2'd2;
    req_wdata = 32'(FID);
    @(negedge clk);
    chk("R10 first pulse", 32'(spi_pulse), 32'd1);
    req_wdata = 32'(FID + NSPI - 1);
    @(negedge clk);
    chk("R10 second pulse", 32'(spi_pulse), 32'(NSPI'(1) << (NSPI - 1)));
    req_wdata = 32'(FID + 3);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 third pulse", 32'(spi_pulse), 32'(NSPI'(1) << 3));
    idle_check("R10 end");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule